// File: doc/BRIEF.md
# Periodic Whole-Packet Thinning Stage

This stage sits inline on a framed packet stream in a router datapath and, while armed, throws away one packet out of every N. Each beat carries a data word plus start and end markers, and moves on a valid/ready handshake. The stage has no storage of its own: accepted beats go straight out in the same cycle, so a downstream stall holds up the upstream side directly. The one exception is a beat of a discarded packet, which upstream may always hand over, because nothing is presented downstream.

Software reaches the stage through a small register port. It writes the period N and an on/off control, and it reads back a running total of discarded packets. Packets are numbered from 1 at each restart of the count. The packet whose number equals N is discarded from its first beat to its last, and numbering then starts again at 1. Writing the period or the control restarts the count, and the restart applies from the next packet that begins. The decision is always made on a packet's first beat, so a packet is never split.

Top module: `pkt_thinner`

## Requirements
- R1: After reset no beat is presented downstream while none is offered, and the control, period and discard-total registers all read 0.
- R2: Register map, byte offsets: 0x700 is the control (bit 0 set = thinning on), 0x704 holds the period N in its low CNT_W bits, and 0x708 holds the discard total, which is read-only so that writes to it are ignored. All other offsets read 0.
- R3: With thinning off, every packet is forwarded whole and unchanged.
- R4: With thinning on and N of 2 or more, packets N, 2N, 3N, ... counted since the last restart are discarded and all others are forwarded. N may be as large as 1000 or more.
- R5: With thinning on, N = 0 discards nothing and N = 1 discards every packet.
- R6: The keep-or-discard choice is taken on the first beat of a packet and applies to every beat up to and including the end beat.
- R7: During every beat of a discarded packet, in_ready is high and out_valid is low.
- R8: During a forwarded packet, out_valid follows in_valid, in_ready follows out_ready, and data, start and end pass through in the same cycle.
- R9: A write to the control or period offset restarts the count, so the first packet that begins after the write is number 1. A packet already in progress keeps its decision.
- R10: The discard total rises by exactly one for each discarded packet, on that packet's first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | REG_AW | Register write byte offset |
| cfg_wdata | input | REG_DW | Register write data |
| cfg_raddr | input | REG_AW | Register read byte offset |
| cfg_rdata | output | REG_DW | Register read data (combinational) |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Stage accepts the upstream beat |
| in_data | input | DATA_W | Upstream beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Downstream beat data |
| out_sop | output | 1 | First beat marker forwarded |
| out_eop | output | 1 | Last beat marker forwarded |

## Verification
The checks assume well-formed framing upstream. The first valid beat after an end beat carries the start marker, and in_valid with its beat stays put until it is taken. The bench drives only whole packets of this form, holds every beat until the handshake completes, and throttles out_ready in a fixed pattern. It issues register writes only between packets or on a non-first beat of a packet in flight, never in the same cycle as a first beat, so the restart point is unambiguous.

// File: rtl/drp_pkg.sv
package drp_pkg;
  // register byte offsets; software depends on these values
  localparam int OFS_CTRL   = 'h700;
  localparam int OFS_PERIOD = 'h704;
  localparam int OFS_TOTAL  = 'h708;
endpackage

// File: rtl/drp_regs.sv
module drp_regs #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  parameter int DCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata,
  input  logic [DCNT_W-1:0] total,
  output logic              arm,
  output logic [CNT_W-1:0]  period,
  output logic              touch
);
  import drp_pkg::*;

  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_PERIOD = AW'(OFS_PERIOD);
  localparam logic [AW-1:0] A_TOTAL  = AW'(OFS_TOTAL);

  logic hit_ctrl, hit_period;

  assign hit_ctrl   = wr && (waddr == A_CTRL);
  assign hit_period = wr && (waddr == A_PERIOD);
  assign touch      = hit_ctrl || hit_period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm    <= 1'b0;
      period <= '0;
    end else begin
      if (hit_ctrl)   arm    <= wdata[0];
      if (hit_period) period <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      A_CTRL:   rdata = DW'(arm);
      A_PERIOD: rdata = DW'(period);
      A_TOTAL:  rdata = DW'(total);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/drp_sched.sv
module drp_sched #(
  parameter int CNT_W  = 16,
  parameter int DCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [CNT_W-1:0]  period,
  input  logic              touch,
  input  logic              take,
  input  logic              take_eop,
  output logic              discard,
  output logic [DCNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             mid_q, keep_drop_q, pend_q;
  logic [CNT_W-1:0] num_q, num_eff;
  logic             active, hit;

  // a pending restart makes the next starting packet number one
  assign num_eff = pend_q ? ONE : num_q;
  assign active  = arm && (period != '0);
  assign hit     = active && (num_eff == period);
  assign discard = mid_q ? keep_drop_q : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q       <= 1'b0;
      keep_drop_q <= 1'b0;
      pend_q      <= 1'b0;
      num_q       <= ONE;
      total       <= '0;
    end else begin
      if (take) begin
        if (!mid_q) begin
          keep_drop_q <= hit;
          mid_q       <= !take_eop;
          pend_q      <= 1'b0;
          num_q       <= (hit || !active) ? ONE : num_eff + ONE;
          if (hit) total <= total + DCNT_W'(1);
        end else if (take_eop) begin
          mid_q <= 1'b0;
        end
      end
      if (touch) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/drp_gate.sv
module drp_gate #(
  parameter int DATA_W = 64
) (
  input  logic              discard,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              take,
  output logic              take_eop
);
  assign out_valid = in_valid && !discard;
  assign in_ready  = discard || out_ready;
  assign out_data  = in_data;
  assign out_sop   = in_sop;
  assign out_eop   = in_eop;
  assign take      = in_valid && in_ready;
  assign take_eop  = in_eop;
endmodule

// File: rtl/pkt_thinner.sv
module pkt_thinner #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 12,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_waddr,
  input  logic [REG_DW-1:0] cfg_wdata,
  input  logic [REG_AW-1:0] cfg_raddr,
  output logic [REG_DW-1:0] cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int DCNT_W = REG_DW;

  logic              arm, touch, discard, take, take_eop;
  logic [CNT_W-1:0]  period;
  logic [DCNT_W-1:0] total;

  drp_regs #(.AW(REG_AW), .DW(REG_DW), .CNT_W(CNT_W), .DCNT_W(DCNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .total(total),
    .arm(arm), .period(period), .touch(touch)
  );

  drp_sched #(.CNT_W(CNT_W), .DCNT_W(DCNT_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .arm(arm), .period(period), .touch(touch),
    .take(take), .take_eop(take_eop), .discard(discard), .total(total)
  );

  drp_gate #(.DATA_W(DATA_W)) u_gate (
    .discard(discard), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .take(take), .take_eop(take_eop)
  );
endmodule

// File: rtl/pkt_thinner_chk.sv
module pkt_thinner_chk #(
  parameter int CNT_W  = 16,
  parameter int DCNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic              arm,
  input logic [CNT_W-1:0]  period,
  input logic [DCNT_W-1:0] total
);
  logic c_mid, c_drp, c_take;

  assign c_take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_mid <= 1'b0;
      c_drp <= 1'b0;
    end else if (c_take) begin
      if (!c_mid) begin
        c_drp <= !out_valid;
        c_mid <= !in_eop;
      end else if (in_eop) begin
        c_mid <= 1'b0;
      end
    end
  end

  AST_HOLD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    c_mid && c_drp && in_valid |-> !out_valid && in_ready); // R6
  AST_HOLD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    c_mid && !c_drp && in_valid |-> out_valid); // R6
  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !c_mid && in_valid && !arm |-> out_valid); // R3
  AST_ZERO_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !c_mid && in_valid && period == '0 |-> out_valid); // R5
  AST_ONE_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    !c_mid && in_valid && arm && period == CNT_W'(1) |-> !out_valid); // R5
  AST_DISCARD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !out_valid |-> in_ready); // R7
  AST_FORWARD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready == out_ready); // R8
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    c_take && !c_mid && !out_valid |=> total == $past(total) + DCNT_W'(1)); // R10
  AST_TOTAL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_take && !c_mid && !out_valid) |=> $stable(total)); // R10
endmodule

bind pkt_thinner pkt_thinner_chk #(.CNT_W(CNT_W), .DCNT_W(DCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
  .arm(arm), .period(period), .total(total)
);

// File: tb/test_pkt_thinner.sv
`timescale 1ns/1ps
module test_pkt_thinner;
  import drp_pkg::*;

  localparam int DW = 32;
  localparam int AW = 12;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          s;
    logic          e;
  } beat_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          cfg_wr;
  logic [AW-1:0] cfg_waddr, cfg_raddr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          in_valid, in_ready, in_sop, in_eop;
  logic [DW-1:0] in_data, out_data;
  logic          out_valid, out_ready, out_sop, out_eop;

  beat_t exp_q[$];
  beat_t mon_e;
  int    vec = 0;
  int    bad = 0;
  bit    en_m = 1'b0;
  int    n_m = 0;
  int    idx_m = 0;
  int    drops_m = 0;
  int    pkt_id = 0;
  int    cyc = 0;
  bit    done = 1'b0;

  pkt_thinner #(.DATA_W(DW), .CNT_W(16), .REG_AW(AW), .REG_DW(32)) i_pkt_thinner (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  // downstream throttle pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = (cyc % 7) != 3 && (cyc % 11) != 5;
  end

  // monitor: compare every forwarded beat with the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      vec++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected beat actual=%h expected none", out_data);
      end else begin
        mon_e = exp_q.pop_front();
        if ({out_data, out_sop, out_eop} != mon_e) begin
          bad++;
          $display("FAIL R8 beat actual=%h/%b/%b expected=%h/%b/%b",
                   out_data, out_sop, out_eop, mon_e.d, mon_e.s, mon_e.e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int addr, input int data);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_waddr = AW'(addr); cfg_wdata = data;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (addr == OFS_CTRL)   begin en_m = data[0]; idx_m = 0; end
    if (addr == OFS_PERIOD) begin n_m = data & 'hFFFF; idx_m = 0; end
  endtask

  task automatic reg_chk(input int addr, input int exp, input string req);
    cfg_raddr = AW'(addr);
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  // driver: one packet; mid_n >= 0 writes a new period during beat 1
  task automatic send_pkt(input int len, input int mid_n);
    bit drop;
    bit acc;
    bit wr_now;
    pkt_id++;
    idx_m++;
    drop = en_m && n_m != 0 && (idx_m % n_m) == 0;
    if (drop) drops_m++;
    for (int b = 0; b < len; b++) begin
      in_valid = 1'b1;
      in_data  = {pkt_id[15:0], b[15:0]};
      in_sop   = (b == 0);
      in_eop   = (b == len - 1);
      if (!drop) exp_q.push_back({in_data, in_sop, in_eop});
      wr_now = (b == 1) && (mid_n >= 0);
      if (wr_now) begin
        cfg_wr = 1'b1; cfg_waddr = AW'(OFS_PERIOD); cfg_wdata = mid_n;
      end
      do begin
        @(negedge clk);
        if (drop) chk(in_ready && !out_valid, "R7", {in_ready, out_valid}, 2);
        acc = in_ready;
        @(posedge clk); #1;
        if (wr_now) begin
          cfg_wr = 1'b0; wr_now = 1'b0;
          n_m = mid_n; idx_m = 0;
        end
      end while (!acc);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic burst(input int cnt, input int len);
    for (int i = 0; i < cnt; i++) send_pkt(len, -1);
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0;
    in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    reg_chk(OFS_CTRL, 0, "R1 control");
    reg_chk(OFS_PERIOD, 0, "R1 period");
    reg_chk(OFS_TOTAL, 0, "R1 total");
    rst_n = 1'b1;

    // R2 map
    reg_wr(OFS_PERIOD, 3);
    reg_chk(OFS_PERIOD, 3, "R2 period readback");
    reg_chk(OFS_CTRL, 0, "R2 control readback");
    reg_chk('h70C, 0, "R2 unmapped offset");

    // R3 off: everything passes
    burst(5, 3);
    drain();
    chk(exp_q.size() == 0, "R3 all forwarded", exp_q.size(), 0);

    // R4 on with N=3
    reg_wr(OFS_CTRL, 1);
    reg_chk(OFS_CTRL, 1, "R2 control on");
    burst(9, 2);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R10 total after N=3");

    // R2 total is read-only
    reg_wr(OFS_TOTAL, 77);
    reg_chk(OFS_TOTAL, drops_m, "R2 total write ignored");

    // R5 N=1 discards all, multi-beat under back-pressure (R6)
    reg_wr(OFS_PERIOD, 1);
    burst(3, 3);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R5 N=1 total");

    // R5 N=0 discards nothing
    reg_wr(OFS_PERIOD, 0);
    burst(4, 2);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R5 N=0 total");

    // R9 period rewrite during a packet keeps that packet's decision
    reg_wr(OFS_PERIOD, 4);
    burst(2, 2);
    send_pkt(3, 2);
    burst(4, 2);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R9 mid-packet rewrite total");

    // R9 control rewrite restarts the count
    reg_wr(OFS_PERIOD, 5);
    burst(3, 1);
    reg_wr(OFS_CTRL, 1);
    burst(5, 1);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R9 control restart total");

    // R4 large period
    reg_wr(OFS_PERIOD, 1000);
    burst(1001, 1);
    drain();
    reg_chk(OFS_TOTAL, drops_m, "R4 N=1000 total");

    // R3 off again
    reg_wr(OFS_CTRL, 0);
    burst(3, 2);
    drain();
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    reg_chk(OFS_TOTAL, drops_m, "R10 final total");

    done = 1'b1;
    summary();
  end
endmodule